// File: doc/BRIEF.md
# Nametable Memory with Screen Mirroring

The video processor sees its background tile maps as a window of four 1 KiB screens, laid out as a 2x2 grid: top-left at window offset 0x000, top-right at 0x400, bottom-left at 0x800 and bottom-right at 0xC00. Each screen holds a 32x30 grid of tile indices (960 bytes) followed by a 64-byte colour-attribute area. The board, however, carries only 2 KiB of storage, so two of the four screens are always aliases of the other two. This block holds that storage and folds the four logical screens onto physical pages using a mirroring rule chosen at run time. When the four-screen build option is enabled, 2 KiB of extra storage is added, and a third rule gives each screen its own page.

An access presents a window offset together with a read or a write strobe. Writes take effect on the clock edge. Read data appears one clock after the read strobe and is held until the next read. The mirroring selection is captured only on cycles with no access in progress. Changing it therefore never interrupts an access, and it only changes how later offsets are routed. Stored bytes are left as they are.

Top module: `nt_vram`

## Requirements
- R1: While reset is high, rdata_o is 0 and the captured mirroring rule is vertical (code 0). The first access after reset therefore uses vertical mirroring, whatever mode_i shows.
- R2: A write stores wdata_i on the clock edge. A read returns, one clock after the strobe, the byte most recently written to the same physical location, including a write made in the cycle just before.
- R3: Vertical rule (code 0): window bit 10 selects the page. Top-left and bottom-left share page 0, and top-right and bottom-right share page 1. Offsets that differ only in bit 11 are the same byte.
- R4: Horizontal rule (code 1): window bit 11 selects the page. Top-left and top-right share page 0, and bottom-left and bottom-right share page 1. Offsets that differ only in bit 10 are the same byte.
- R5: Four-screen rule (code 2, with the four-screen option built in): each screen has its own page. Top-left uses page 0, top-right page 1, bottom-left page 2 and bottom-right page 3, so all 4096 window bytes are distinct.
- R6: mode_i is captured only on a cycle where rd_i and wr_i are both low, and it takes effect from the next access. A value on mode_i during an access is ignored.
- R7: Changing the mirroring rule alters no stored byte. Pages 0 and 1 keep their contents across every change of rule.
- R8: rdata_o keeps its value on every cycle without a read. When rd_i and wr_i are high together, the write is performed and rdata_o is held.
- R9: Code 3 acts as the vertical rule. In a build without the four-screen option, code 2 also acts as the vertical rule.
- R10: The low bits of the offset (within a screen) pass to the page unchanged. Tile bytes (0-959) and attribute bytes (960-1023) of a screen are stored alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | SCREEN_AW+2 (12) | Offset within the four-screen window |
| wdata_i | input | DATA_W (8) | Write data |
| mode_i | input | 2 | Mirroring rule: 0 vertical, 1 horizontal, 2 four-screen, 3 as vertical |
| rdata_o | output | DATA_W (8) | Registered read data |

## Verification
The bench builds two instances and drives both with the same stimulus. The first uses the default 1 KiB screens with four-screen storage, so every offset of the real window, including the attribute tail of each screen, is written once and then checked under all three rules. The second shrinks each screen to 16 bytes and leaves out the extra storage. Its whole physical space is covered by the same fill, and it shows the code-2 fallback to vertical mirroring running side by side with the four-screen build.

// File: rtl/nt_vram_pkg.sv
package nt_vram_pkg;

    // Mirroring rule codes as seen on mode_i
    typedef enum logic [1:0] {
        MIR_VERT = 2'd0,
        MIR_HORZ = 2'd1,
        MIR_FOUR = 2'd2,
        MIR_RSVD = 2'd3
    } mir_mode_e;

    typedef struct packed {
        mir_mode_e mode;
    } hold_st_t;

endpackage

// File: rtl/nt_mode_hold.sv
module nt_mode_hold
    import nt_vram_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       busy_i,
    input  logic [1:0] mode_i,
    output mir_mode_e  mode_o
);

    hold_st_t st_d, st_q;

    // Capture the requested rule only while the port is idle
    always_comb begin
        st_d = st_q;
        if (!busy_i) begin
            st_d.mode = mir_mode_e'(mode_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.mode <= MIR_VERT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/nt_page_map.sv
module nt_page_map
    import nt_vram_pkg::*;
#(
    parameter bit FOUR_EN = 1'b1,
    localparam int PAGE_W = FOUR_EN ? 2 : 1
) (
    input  logic [1:0]        quad_i,
    input  mir_mode_e         mode_i,
    output logic [PAGE_W-1:0] page_o
);

    // quad_i[0] is the column (window bit 10), quad_i[1] the row (bit 11)
    generate
        if (FOUR_EN) begin : g_four
            always_comb begin
                unique case (mode_i)
                    MIR_HORZ: page_o = {1'b0, quad_i[1]};
                    MIR_FOUR: page_o = quad_i;
                    default:  page_o = {1'b0, quad_i[0]};
                endcase
            end
        end else begin : g_two
            always_comb begin
                page_o = (mode_i == MIR_HORZ) ? quad_i[1] : quad_i[0];
            end
        end
    endgenerate

endmodule

// File: rtl/nt_ram.sv
module nt_ram #(
    parameter int AW = 11,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          re_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [0:DEPTH-1];
    logic [DW-1:0] rd_d, rd_q;

    // A write wins over a read in the same cycle; the output then holds
    always_comb begin
        rd_d = rd_q;
        if (re_i && !we_i) begin
            rd_d = mem[addr_i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/nt_vram.sv
module nt_vram
    import nt_vram_pkg::*;
#(
    parameter int SCREEN_AW = 10,
    parameter int DATA_W    = 8,
    parameter bit FOUR_EN   = 1'b1,
    localparam int WIN_AW  = SCREEN_AW + 2,
    localparam int PAGE_W  = FOUR_EN ? 2 : 1,
    localparam int PHYS_AW = SCREEN_AW + PAGE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [WIN_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [1:0]        mode_i,
    output logic [DATA_W-1:0] rdata_o
);

    mir_mode_e            cur_mode;
    logic                 busy;
    logic [1:0]           quad;
    logic [SCREEN_AW-1:0] offset;
    logic [PAGE_W-1:0]    page;
    logic [PHYS_AW-1:0]   phys_addr;

    always_comb begin
        busy      = rd_i | wr_i;
        quad      = addr_i[WIN_AW-1 -: 2];
        offset    = addr_i[SCREEN_AW-1:0];
        phys_addr = {page, offset};
    end

    nt_mode_hold u_hold (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .busy_i (busy),
        .mode_i (mode_i),
        .mode_o (cur_mode)
    );

    nt_page_map #(
        .FOUR_EN (FOUR_EN)
    ) u_map (
        .quad_i (quad),
        .mode_i (cur_mode),
        .page_o (page)
    );

    nt_ram #(
        .AW (PHYS_AW),
        .DW (DATA_W)
    ) u_ram (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .re_i    (rd_i),
        .we_i    (wr_i),
        .addr_i  (phys_addr),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

endmodule

// File: rtl/nt_vram_chk.sv
module nt_vram_chk #(
    parameter int WIN_AW = 12,
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [WIN_AW-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [1:0]        mode_i,
    input logic [1:0]        mode_q,
    input logic [DATA_W-1:0] rdata_o
);

    localparam logic [WIN_AW-1:0] ROW_FLIP = {1'b1, {(WIN_AW-1){1'b0}}};
    localparam logic [WIN_AW-1:0] COL_FLIP = {2'b01, {(WIN_AW-2){1'b0}}};

    AST_WR_THEN_RD: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !wr_i && $past(wr_i) && addr_i == $past(addr_i))
        |=> rdata_o == $past(wdata_i, 2)); // R2

    AST_VERT_ALIAS: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !wr_i && $past(wr_i) && mode_q == 2'd0 &&
         addr_i == ($past(addr_i) ^ ROW_FLIP))
        |=> rdata_o == $past(wdata_i, 2)); // R3

    AST_HORZ_ALIAS: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !wr_i && $past(wr_i) && mode_q == 2'd1 &&
         addr_i == ($past(addr_i) ^ COL_FLIP))
        |=> rdata_o == $past(wdata_i, 2)); // R4

    AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i || wr_i) |=> $stable(mode_q)); // R6

    AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rd_i && !wr_i) |=> mode_q == $past(mode_i)); // R6

    AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rd_i && !wr_i) |=> $stable(rdata_o)); // R8

endmodule

bind nt_vram nt_vram_chk #(
    .WIN_AW (WIN_AW),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mode_i  (mode_i),
    .mode_q  (cur_mode),
    .rdata_o (rdata_o)
);

// File: tb/sim_nt_vram.sv
module sim_nt_vram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [5:0]  addr1;
    logic [7:0]  wdata = '0;
    logic [1:0]  mode = '0;
    logic [7:0]  rdata0, rdata1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference storage, indexed by physical byte number
    int m0 [4096];
    int m1 [32];
    int e0 = 0;
    int e1 = 0;
    int em = 0;

    always #2 clk = ~clk;

    assign addr1 = {addr[11:10], addr[3:0]};

    nt_vram u0 (
        .clk_i (clk), .rst_i (rst), .rd_i (rd), .wr_i (wr),
        .addr_i (addr), .wdata_i (wdata), .mode_i (mode), .rdata_o (rdata0)
    );

    nt_vram #(.SCREEN_AW (4), .FOUR_EN (1'b0)) u1 (
        .clk_i (clk), .rst_i (rst), .rd_i (rd), .wr_i (wr),
        .addr_i (addr1), .wdata_i (wdata), .mode_i (mode), .rdata_o (rdata1)
    );

    function automatic int phys(input int a, input int md, input int four, input int saw);
        int q = a >> saw;
        int off = a % (1 << saw);
        int pg;
        if (md == 1) pg = q / 2;
        else if (md == 2 && four != 0) pg = q;
        else pg = q % 2;
        return pg * (1 << saw) + off;
    endfunction

    task automatic chk(input logic [7:0] act, input int exp, input string tag);
        checks++;
        if (act !== exp[7:0]) begin
            errors++;
            $display("FAIL %s: rdata=%0h expected=%0h", tag, act, exp[7:0]);
        end
    endtask

    // One clock: drive at the falling edge, compare at the next one
    task automatic cyc(input bit r, input bit w, input int a, input int d,
                       input int md, input string tag0, input string tag1);
        int a1;
        rd = r; wr = w; addr = a[11:0]; wdata = d[7:0]; mode = md[1:0];
        a1 = ((a >> 10) << 4) | (a % 16);
        if (w) begin
            m0[phys(a, em, 1, 10)] = d % 256;
            m1[phys(a1, em, 0, 4)] = d % 256;
        end else if (r) begin
            e0 = m0[phys(a, em, 1, 10)];
            e1 = m1[phys(a1, em, 0, 4)];
        end
        if (!r && !w) em = md;
        @(negedge clk);
        chk(rdata0, e0, tag0);
        chk(rdata1, e1, tag1);
    endtask

    task automatic idle(input int md, input string tag);
        cyc(0, 0, 0, 0, md, tag, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(rdata0, 0, "R1 reset u0");
        chk(rdata1, 0, "R1 reset u1");
        rst = 1'b0;
        // First access straight after reset uses vertical rule despite mode_i=1
        cyc(0, 1, 12'h003, 8'hA5, 1, "R1", "R1");
        cyc(1, 0, 12'h803, 0, 1, "R1 R6", "R1 R6");
        // mode_i toggles during accesses: still vertical
        cyc(1, 0, 12'h003, 0, 2, "R6", "R6");
        cyc(1, 0, 12'h803, 0, 1, "R6", "R6");

        // Fill every byte of the window under the four-screen rule
        idle(2, "R8");
        for (int i = 0; i < 4096; i++) begin
            cyc(0, 1, i, (i * 7 + 3) % 256, 2, "R2", "R9");
        end
        // Four screens distinct in u0; code 2 falls back to vertical in u1
        for (int q = 0; q < 4; q++) begin
            cyc(1, 0, q * 1024 + 5, 0, 2, "R5", "R9");
            cyc(1, 0, q * 1024 + 960, 0, 2, "R5 R10", "R9");
            cyc(1, 0, q * 1024 + 1023, 0, 2, "R5 R10", "R9");
        end

        // Write then read at once, same offset
        cyc(0, 1, 12'h456, 8'h3C, 2, "R2", "R2");
        cyc(1, 0, 12'h456, 0, 2, "R2", "R2");

        // Vertical rule
        idle(0, "R8");
        cyc(0, 1, 12'h005, 8'h11, 0, "R3", "R3");
        cyc(1, 0, 12'h805, 0, 0, "R3", "R3");
        cyc(0, 1, 12'hC10, 8'h22, 0, "R3", "R3");
        cyc(1, 0, 12'h410, 0, 0, "R3", "R3");
        cyc(1, 0, 12'h3C7, 0, 0, "R3 R10", "R3 R10");

        // Horizontal rule
        idle(1, "R8");
        cyc(0, 1, 12'h407, 8'h33, 1, "R4", "R4");
        cyc(1, 0, 12'h007, 0, 1, "R4", "R4");
        cyc(0, 1, 12'h8FF, 8'h44, 1, "R4", "R4");
        cyc(1, 0, 12'hCFF, 0, 1, "R4", "R4");
        cyc(0, 1, 12'hBC1, 8'h55, 1, "R4 R10", "R4 R10");
        cyc(1, 0, 12'hFC1, 0, 1, "R4 R10", "R4 R10");

        // Read together with write: data held, write lands
        cyc(1, 1, 12'h123, 8'h66, 1, "R8", "R8");
        cyc(0, 0, 0, 0, 1, "R8", "R8");
        cyc(1, 0, 12'h523, 0, 1, "R8", "R8");

        // Rule changes keep contents
        idle(2, "R7");
        for (int q = 0; q < 4; q++) begin
            cyc(1, 0, q * 1024 + 7, 0, 2, "R7", "R7");
            cyc(1, 0, q * 1024 + 255, 0, 2, "R7", "R7");
        end
        idle(0, "R7");
        cyc(1, 0, 12'h005, 0, 0, "R7", "R7");

        // Reserved code acts as vertical
        idle(3, "R9");
        cyc(0, 1, 12'h020, 8'h77, 3, "R9", "R9");
        cyc(1, 0, 12'h820, 0, 3, "R9", "R9");
        cyc(1, 0, 12'hC20, 0, 3, "R9", "R9");

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int k = int'($urandom % 4);
            int a = int'($urandom % 4096);
            int d = int'($urandom % 256);
            int md = int'($urandom % 4);
            cyc(k[0], k[1], a, d, md, "R2 R6", "R2 R6");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule